// File: doc/BRIEF.md
# Windowed Rectify-and-Integrate Accumulator

This block receives a stream of signed 10-bit samples qualified by a sample strobe (one strobe per 5 µs sample period). It takes the magnitude of each sample and adds it into an integrator, but only while an external window input is high. Each rising edge of the window opens a new integration window. That edge clears the integrator and the clamp flag, and it latches the time-constant code that scales the window. While the window is low, the result stays frozen so that a serial readout and a DAC can pick it up.

The rate of integration is set by a 5-bit code. The code selects one of 32 time constants between 40 µs and 600 µs, and each step adds the sample magnitude times the ratio of the sample period to that time constant. The integrator keeps eight fractional bits internally. Its 10-bit integer part is the output, and the output saturates at full scale instead of wrapping. A flag records that saturation happened during the current window.

Top module: `rect_win_integ`

## Requirements
- R1: After reset, level_o is 0 and clamp_o is 0.
- R2: A sample is treated as two's complement and its magnitude is used, so -512 contributes 512 and -1 contributes 1.
- R3: The integrator changes only in a cycle where win_i is high and smp_vld_i is high. With smp_vld_i low it keeps its value.
- R4: In a cycle where win_i is high and was low in the previous cycle, the integrator and clamp_o restart from zero. A valid sample in that same cycle is added after the restart.
- R5: The integrator saturates at all ones (level_o = 1023) and never wraps.
- R6: clamp_o goes to 1 in the cycle the integrator saturates. It stays at 1 until the next window start and is 0 if no saturation happened in the current window.
- R7: Time constant in µs for code c: 40+5c for c in 0..8, 90+10(c-9) for c in 9..16, 180+20(c-17) for c in 17..24, and 360+40(c-25) for c in 25..31. The coefficient is round(1280/tc). Each step adds |x|·coefficient to an integrator with 8 fractional bits, and level_o is its integer part.
- R8: tc_code_i is sampled only in the window-start cycle. Changes in the middle of a window have no effect until the next start.
- R9: While win_i is low, level_o and clamp_o hold their values.
- R10: The effect of a sample is visible on level_o and clamp_o after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 10 | Signed sample |
| win_i | input | 1 | Integration window (high = integrate, low = hold) |
| tc_code_i | input | 5 | Time-constant code |
| level_o | output | 10 | Integer part of the integrator |
| clamp_o | output | 1 | Saturation flag for the current window |

## Verification
The bench aims at the most negative sample. A design that negates it in too narrow a width adds 0 or a negative value instead of 512. It drives long runs of full-scale samples with the fastest time constant, which exposes a design that wraps past 1023 or that lets the clamp flag fall before the next window. It changes the time-constant code in the middle of a window, which would change the slope of a design that does not latch the code. It also places valid samples in the window-start cycle, where a design that clears after adding would lose the first sample. Random windows, samples and codes are checked every cycle against a bench model.

// File: rtl/rwi_pkg.sv
package rwi_pkg;
    // time constant in microseconds for a 5-bit code, piecewise linear in four segments
    function automatic int tc_us(input int code);
        if (code < 9)
            return 40 + 5 * code;
        else if (code < 17)
            return 90 + 10 * (code - 9);
        else if (code < 25)
            return 180 + 20 * (code - 17);
        else
            return 360 + 40 * (code - 25);
    endfunction

    // rounded fixed-point ratio of sample period to time constant
    function automatic int step_coef(input int code, input int smp_us, input int frac_w);
        int tc;
        tc = tc_us(code);
        return ((smp_us << frac_w) + tc / 2) / tc;
    endfunction
endpackage

// File: rtl/rwi_rectify.sv
module rwi_rectify #(
    parameter int SMP_W = 10
) (
    input  logic [SMP_W-1:0] smp_i,
    output logic [SMP_W-1:0] mag_o
);
    // the unsigned result is as wide as the input, so the most negative code maps to 2^(SMP_W-1)
    always_comb begin
        if (smp_i[SMP_W-1])
            mag_o = ~smp_i + 1'b1;
        else
            mag_o = smp_i;
    end
endmodule

// File: rtl/rwi_coef_lut.sv
module rwi_coef_lut
    import rwi_pkg::*;
#(
    parameter int TC_W   = 5,
    parameter int COEF_W = 8,
    parameter int FRAC_W = 8,
    parameter int SMP_US = 5
) (
    input  logic [TC_W-1:0]   code_i,
    output logic [COEF_W-1:0] coef_o
);
    localparam int N_TC = 1 << TC_W;

    logic [COEF_W-1:0] table_w [N_TC];

    for (genvar g = 0; g < N_TC; g++) begin : g_entry
        assign table_w[g] = COEF_W'(step_coef(g, SMP_US, FRAC_W));
    end

    assign coef_o = table_w[code_i];
endmodule

// File: rtl/rwi_accum.sv
module rwi_accum #(
    parameter int SMP_W  = 10,
    parameter int OUT_W  = 10,
    parameter int FRAC_W = 8,
    parameter int TC_W   = 5,
    parameter int COEF_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld_i,
    input  logic [SMP_W-1:0]        mag_i,
    input  logic                    win_i,
    input  logic [TC_W-1:0]         tc_code_i,
    input  logic [COEF_W-1:0]       coef_i,
    output logic [TC_W-1:0]         tc_sel_o,
    output logic [OUT_W+FRAC_W-1:0] acc_o,
    output logic                    sat_o
);
    localparam int ACC_W = OUT_W + FRAC_W;
    localparam int MUL_W = SMP_W + COEF_W;
    localparam int SUM_W = ((MUL_W > ACC_W) ? MUL_W : ACC_W) + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             sat;
        logic             win;
        logic [TC_W-1:0]  tc;
    } state_t;

    state_t st_q, st_d;

    logic             start_w;
    logic [MUL_W-1:0] step_w;
    logic [SUM_W-1:0] sum_w;

    assign start_w  = win_i & ~st_q.win;
    // the start cycle uses the new code so that its sample is scaled like the rest of the window
    assign tc_sel_o = start_w ? tc_code_i : st_q.tc;
    assign step_w   = MUL_W'(mag_i) * MUL_W'(coef_i);

    always_comb begin
        st_d     = st_q;
        st_d.win = win_i;
        if (start_w) begin
            st_d.acc = '0;
            st_d.sat = 1'b0;
            st_d.tc  = tc_code_i;
        end
        sum_w = SUM_W'(st_d.acc) + SUM_W'(step_w);
        if (win_i && smp_vld_i) begin
            if (sum_w > SUM_W'(ACC_MAX)) begin
                st_d.acc = ACC_MAX;
                st_d.sat = 1'b1;
            end else begin
                st_d.acc = sum_w[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;
    assign sat_o = st_q.sat;

    // R5: inside a window the integrator only grows or stays
    a_r5_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !start_w |=> (st_q.acc >= $past(st_q.acc)));

    // R9: with the window low the integrator is frozen
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !win_i |=> $stable(st_q.acc) && $stable(st_q.sat));

    // R6: the clamp flag stays up until a new window starts
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sat && !start_w) |=> st_q.sat);

    // R6: a raised flag means the integrator sits at full scale
    a_r6_full: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sat |-> (st_q.acc == ACC_MAX));

    // R4: a start without a sample leaves a cleared integrator and flag
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && !smp_vld_i) |=> (st_q.acc == '0) && !st_q.sat);

    // R8: the latched code moves only on a window start
    a_r8_tc_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !start_w |=> $stable(st_q.tc));
endmodule

// File: rtl/rect_win_integ.sv
module rect_win_integ #(
    parameter int SMP_W  = 10,
    parameter int OUT_W  = 10,
    parameter int FRAC_W = 8,
    parameter int TC_W   = 5,
    parameter int COEF_W = 8,
    parameter int SMP_US = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             win_i,
    input  logic [TC_W-1:0]  tc_code_i,
    output logic [OUT_W-1:0] level_o,
    output logic             clamp_o
);
    localparam int ACC_W = OUT_W + FRAC_W;

    logic [SMP_W-1:0]  mag_w;
    logic [COEF_W-1:0] coef_w;
    logic [TC_W-1:0]   tc_sel_w;
    logic [ACC_W-1:0]  acc_w;

    rwi_rectify #(.SMP_W(SMP_W)) u_rect (
        .smp_i (smp_i),
        .mag_o (mag_w)
    );

    rwi_coef_lut #(
        .TC_W  (TC_W),
        .COEF_W(COEF_W),
        .FRAC_W(FRAC_W),
        .SMP_US(SMP_US)
    ) u_lut (
        .code_i(tc_sel_w),
        .coef_o(coef_w)
    );

    rwi_accum #(
        .SMP_W (SMP_W),
        .OUT_W (OUT_W),
        .FRAC_W(FRAC_W),
        .TC_W  (TC_W),
        .COEF_W(COEF_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld_i(smp_vld_i),
        .mag_i    (mag_w),
        .win_i    (win_i),
        .tc_code_i(tc_code_i),
        .coef_i   (coef_w),
        .tc_sel_o (tc_sel_w),
        .acc_o    (acc_w),
        .sat_o    (clamp_o)
    );

    assign level_o = acc_w[ACC_W-1 -: OUT_W];

    // R1: right after reset the outputs are clear
    a_r1_reset: assert property (@(posedge clk) $rose(rst_n) |-> (level_o == '0) && !clamp_o);
endmodule

// File: tb/rect_win_integ_bench.sv
module rect_win_integ_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld_i = 1'b0;
    logic [9:0] smp_i = '0;
    logic       win_i = 1'b0;
    logic [4:0] tc_code_i = '0;
    logic [9:0] level_o;
    logic       clamp_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_acc = 0;
    bit m_sat = 1'b0;
    bit m_win = 1'b0;
    int m_tc  = 0;

    always #4 clk = ~clk;

    rect_win_integ u_rect_win_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld_i(smp_vld_i),
        .smp_i    (smp_i),
        .win_i    (win_i),
        .tc_code_i(tc_code_i),
        .level_o  (level_o),
        .clamp_o  (clamp_o)
    );

    function automatic int exp_coef(input int c);
        int t;
        if (c <= 8)       t = 40 + 5 * c;
        else if (c <= 16) t = 90 + 10 * (c - 9);
        else if (c <= 24) t = 180 + 20 * (c - 17);
        else              t = 360 + 40 * (c - 25);
        return (1280 + t / 2) / t;
    endfunction

    function automatic int exp_mag(input int v);
        int s;
        s = (v >= 512) ? v - 1024 : v;
        return (s < 0) ? -s : s;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit vld, input int data, input bit win, input int tc, input string tag);
        bit    start;
        int    sum;
        string t;
        @(negedge clk);
        smp_vld_i = vld;
        smp_i     = 10'(data);
        win_i     = win;
        tc_code_i = 5'(tc);
        start = win && !m_win;
        if (start) begin
            m_acc = 0;
            m_sat = 1'b0;
            m_tc  = tc;
        end
        if (win && vld) begin
            sum = m_acc + exp_mag(data) * exp_coef(m_tc);
            if (sum > 262143) begin
                m_acc = 262143;
                m_sat = 1'b1;
            end else begin
                m_acc = sum;
            end
        end
        m_win = win;
        if (tag != "") t = tag;
        else if (start) t = "R4";
        else if (!win) t = "R9";
        else if (!vld) t = "R3";
        else if (m_sat) t = "R5";
        else t = "R7";
        @(posedge clk);
        #1;
        check({t, " level"}, int'(level_o), m_acc >> 8);
        check({t == "R5" ? "R6" : t, " clamp"}, int'(clamp_o), int'(m_sat));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0017);
        repeat (3) @(negedge clk);
        check("R1 level", int'(level_o), 0);
        check("R1 clamp", int'(clamp_o), 0);
        rst_n = 1'b1;
        step(1'b0, 0, 1'b0, 0, "R1");

        // R2 and R10: most negative sample at the fastest constant adds exactly 64.0
        step(1'b1, 512, 1'b1, 0, "R2");
        step(1'b1, 1023, 1'b1, 0, "R2");
        step(1'b0, 300, 1'b1, 0, "R3");
        step(1'b1, 5, 1'b0, 0, "R9");
        step(1'b1, 512, 1'b0, 0, "R9");

        // R5 and R6: drive past full scale, then hold and restart
        for (int i = 0; i < 20; i++) step(1'b1, 512, 1'b1, 0, "R5");
        step(1'b1, 511, 1'b1, 0, "R6");
        step(1'b0, 0, 1'b0, 0, "R6");
        step(1'b1, 100, 1'b1, 3, "R4");

        // R8: code change inside a window keeps the latched slope
        for (int i = 0; i < 6; i++) step(1'b1, 200, 1'b1, 31, "R8");
        step(1'b0, 0, 1'b0, 31, "R9");
        step(1'b1, 200, 1'b1, 31, "R7");
        step(1'b1, 511, 1'b1, 8, "R8");

        // R7: every code once at the start of a short window
        for (int c = 0; c < 32; c++) begin
            step(1'b0, 0, 1'b0, c, "R9");
            step(1'b1, 400, 1'b1, c, "R7");
            step(1'b1, 623, 1'b1, (c + 7) % 32, "R7");
        end

        // random windows, samples and codes
        for (int w = 0; w < 300; w++) begin
            int len;
            int gap;
            len = 1 + int'($urandom % 40);
            gap = int'($urandom % 4);
            for (int k = 0; k < len; k++)
                step(($urandom % 4) != 0, int'($urandom % 1024), 1'b1, int'($urandom % 32), "");
            for (int k = 0; k < gap; k++)
                step($urandom % 2 == 1, int'($urandom % 1024), 1'b0, int'($urandom % 32), "");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule